// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one instruction operand specifier into either an effective address or an immediate operand value. Each request carries a 4-bit mode code, a primary register index, an optional secondary register index, a 16-bit offset/address field and the address of the next instruction. The block reads register contents through two combinational read ports. For the auto-step modes it writes the stepped register value back through one write port. For the pointer-through-memory mode it issues a single word read on a simple request/response memory port.

A request is taken with `start_i` while the unit is idle. Every mode except the memory-pointer mode completes one clock later. The memory-pointer mode stays busy until the memory returns its word. The result is presented with a one-cycle `done_o` pulse and three qualifier flags. Decode, operand fetch and the ALU sit outside this block.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (register operand) completes with `is_reg_o`=1, `ea_o`=0, no register write and no memory request.
- R2: Mode code 1 (immediate) returns the 16-bit field sign-extended to 32 bits on `ea_o`, with `is_imm_o`=1.
- R3: Mode code 2 (absolute) returns the 16-bit field zero-extended as the effective address.
- R4: Mode code 3 (register indirect) returns the contents of register Ri as the effective address.
- R5: Mode code 4 (memory pointer) holds `mem_req_o` high with `mem_addr_o` equal to the zero-extended field until `mem_rvalid_i`. The word returned in that cycle appears on `ea_o` with `done_o` one cycle later.
- R6: Mode code 5 (indexed) returns the sign-extended field plus Ri and writes no register.
- R7: Mode code 6 returns Ri+Rj, and mode code 7 returns the sign-extended field plus Ri plus Rj.
- R8: Mode code 8 (relative) returns the sign-extended field plus the next-instruction address `pc_i`. For example, a field of -16 with `pc_i`=1016 gives 1000.
- R9: Mode code 9 (post-increment) returns Ri. In the same cycle as `done_o`, it writes Ri+4 to register Ri.
- R10: Mode code 10 (pre-decrement) returns Ri-4. In the same cycle as `done_o`, it writes that same value to register Ri.
- R11: Mode codes 11 to 15 complete with `illegal_o`=1 and `ea_o`=0, with no register write and no memory request.
- R12: After reset, `done_o`, `busy_o`, `mem_req_o` and `wr_en_o` are 0. Non-memory modes raise `done_o` exactly one cycle after `start_i`. A `start_i` raised while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when idle |
| mode_i | input | 4 | Mode code |
| ri_i | input | 3 | Primary register index |
| rj_i | input | 3 | Secondary register index |
| field_i | input | 16 | Offset, constant or address field |
| pc_i | input | 32 | Next-instruction address |
| rd_a_idx_o | output | 3 | Read port A index (follows ri_i) |
| rd_a_data_i | input | 32 | Read port A data |
| rd_b_idx_o | output | 3 | Read port B index (follows rj_i) |
| rd_b_data_i | input | 32 | Read port B data |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 3 | Register write index |
| wr_data_o | output | 32 | Register write data |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rvalid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | 32 | Pointer read data |
| busy_o | output | 1 | Waiting on memory |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 32 | Effective address or immediate value |
| is_imm_o | output | 1 | Result is an immediate value |
| is_reg_o | output | 1 | Operand is a register, no address |
| illegal_o | output | 1 | Unassigned mode code |

## Verification
Several properties are checked on every cycle. A register write only ever comes with a result and steps the register by exactly one word. The memory address holds steady while a request is pending. Illegal and register-only results cause no side effects, and at most one qualifier flag is set. The bench scenarios cover the arithmetic of each mode, since a property cannot restate it, along with the sign and zero extension of the field and the exact one-cycle latency. They also show that the register file really changes after the auto-step modes and stays unchanged after index modes. Finally, they show that a request made during a pending memory read produces no second result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_REG     = 4'd0,
    M_IMM     = 4'd1,
    M_ABS     = 4'd2,
    M_RIND    = 4'd3,
    M_MIND    = 4'd4,
    M_IDX     = 4'd5,
    M_BASE    = 4'd6,
    M_BASEOFF = 4'd7,
    M_REL     = 4'd8,
    M_AINC    = 4'd9,
    M_ADEC    = 4'd10
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [3:0]    mode_i,
  input  logic [FW-1:0] field_i,
  input  logic [AW-1:0] ri_val_i,
  input  logic [AW-1:0] rj_val_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_o,
  output logic          wb_en_o,
  output logic          is_mem_o,
  output logic          is_imm_o,
  output logic          is_reg_o,
  output logic          illegal_o
);
  localparam int EXT_W = AW - FW;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] sext, zext;
  assign sext = {{EXT_W{field_i[FW-1]}}, field_i};
  assign zext = {{EXT_W{1'b0}}, field_i};

  always_comb begin
    ea_o      = '0;
    wb_o      = ri_val_i;
    wb_en_o   = 1'b0;
    is_mem_o  = 1'b0;
    is_imm_o  = 1'b0;
    is_reg_o  = 1'b0;
    illegal_o = 1'b0;
    case (mode_i)
      M_REG:     is_reg_o = 1'b1;
      M_IMM:     begin ea_o = sext; is_imm_o = 1'b1; end
      M_ABS:     ea_o = zext;
      M_RIND:    ea_o = ri_val_i;
      M_MIND:    begin ea_o = zext; is_mem_o = 1'b1; end
      M_IDX:     ea_o = sext + ri_val_i;
      M_BASE:    ea_o = ri_val_i + rj_val_i;
      M_BASEOFF: ea_o = sext + ri_val_i + rj_val_i;
      M_REL:     ea_o = sext + pc_i;
      M_AINC: begin
        ea_o    = ri_val_i;
        wb_o    = ri_val_i + STEP;
        wb_en_o = 1'b1;
      end
      M_ADEC: begin
        ea_o    = ri_val_i - STEP;
        wb_o    = ri_val_i - STEP;
        wb_en_o = 1'b1;
      end
      default:   illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    a_flags_onehot_r11: assert ($onehot0({is_imm_o, is_reg_o, illegal_o, is_mem_o}));
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW         = 32,
  parameter int RIDX_W     = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RIDX_W-1:0] ri_i,
  input  logic [AW-1:0]     calc_ea_i,
  input  logic [AW-1:0]     calc_wb_i,
  input  logic              calc_wb_en_i,
  input  logic              calc_mem_i,
  input  logic              calc_imm_i,
  input  logic              calc_reg_i,
  input  logic              calc_ill_i,
  input  logic              mem_rvalid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [AW-1:0]     wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     ea_o,
  output logic              is_imm_o,
  output logic              is_reg_o,
  output logic              illegal_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  ea_state_e         state_q;
  logic [AW-1:0]     addr_q, ea_q, wdata_q;
  logic [RIDX_W-1:0] widx_q;
  logic              done_q, wen_q, imm_q, reg_q, ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ea_q    <= '0;
      wdata_q <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
      wen_q   <= 1'b0;
      imm_q   <= 1'b0;
      reg_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wen_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (calc_mem_i) begin
              state_q <= ST_MEM;
              addr_q  <= calc_ea_i;
            end else begin
              done_q  <= 1'b1;
              ea_q    <= calc_ea_i;
              imm_q   <= calc_imm_i;
              reg_q   <= calc_reg_i;
              ill_q   <= calc_ill_i;
              wen_q   <= calc_wb_en_i;
              wdata_q <= calc_wb_i;
              widx_q  <= ri_i;
            end
          end
        end
        ST_MEM: begin
          if (mem_rvalid_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            ea_q    <= mem_rdata_i;
            imm_q   <= 1'b0;
            reg_q   <= 1'b0;
            ill_q   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_MEM);
  assign busy_o     = (state_q == ST_MEM);
  assign mem_addr_o = addr_q;
  assign wr_en_o    = wen_q;
  assign wr_idx_o   = widx_q;
  assign wr_data_o  = wdata_q;
  assign done_o     = done_q;
  assign ea_o       = ea_q;
  assign is_imm_o   = imm_q;
  assign is_reg_o   = reg_q;
  assign illegal_o  = ill_q;

  p_wr_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_q |-> done_q);

  p_wr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_q |-> ((wdata_q == ea_q + STEP) || (wdata_q == ea_q)));

  p_no_side_illegal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && (ill_q || reg_q)) |-> (!wen_q && !mem_req_o));

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(addr_q)));

  p_mem_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (done_q && !mem_req_o && $past(mem_rdata_i) == ea_q));
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FW         = 16,
  parameter int RIDX_W     = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [RIDX_W-1:0] ri_i,
  input  logic [RIDX_W-1:0] rj_i,
  input  logic [FW-1:0]     field_i,
  input  logic [AW-1:0]     pc_i,
  output logic [RIDX_W-1:0] rd_a_idx_o,
  input  logic [AW-1:0]     rd_a_data_i,
  output logic [RIDX_W-1:0] rd_b_idx_o,
  input  logic [AW-1:0]     rd_b_data_i,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [AW-1:0]     wr_data_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     ea_o,
  output logic              is_imm_o,
  output logic              is_reg_o,
  output logic              illegal_o
);
  logic [AW-1:0] c_ea, c_wb;
  logic          c_wb_en, c_mem, c_imm, c_reg, c_ill;

  assign rd_a_idx_o = ri_i;
  assign rd_b_idx_o = rj_i;

  ea_calc #(.AW(AW), .FW(FW), .WORD_BYTES(WORD_BYTES)) u_calc (
    .mode_i    (mode_i),
    .field_i   (field_i),
    .ri_val_i  (rd_a_data_i),
    .rj_val_i  (rd_b_data_i),
    .pc_i      (pc_i),
    .ea_o      (c_ea),
    .wb_o      (c_wb),
    .wb_en_o   (c_wb_en),
    .is_mem_o  (c_mem),
    .is_imm_o  (c_imm),
    .is_reg_o  (c_reg),
    .illegal_o (c_ill)
  );

  ea_ctrl #(.AW(AW), .RIDX_W(RIDX_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ri_i         (ri_i),
    .calc_ea_i    (c_ea),
    .calc_wb_i    (c_wb),
    .calc_wb_en_i (c_wb_en),
    .calc_mem_i   (c_mem),
    .calc_imm_i   (c_imm),
    .calc_reg_i   (c_reg),
    .calc_ill_i   (c_ill),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .wr_data_o    (wr_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ea_o         (ea_o),
    .is_imm_o     (is_imm_o),
    .is_reg_o     (is_reg_o),
    .illegal_o    (illegal_o)
  );

  p_start_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !c_mem) |=> done_o);
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  ri = '0, rj = '0;
  logic [15:0] field = '0;
  logic [31:0] pc = '0;
  logic [2:0]  ra_idx, rb_idx, w_idx;
  logic [31:0] ra_dat, rb_dat, w_dat, m_addr, ea;
  logic        w_en, m_req, busy, done, is_imm, is_reg, ill;
  logic        m_rvalid = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [31:0] regs [8];
  int          m_cnt = 0;
  int          total = 0, bad = 0, writes = 0, dones = 0;

  always #5 clk = ~clk;

  assign ra_dat = regs[ra_idx];
  assign rb_dat = regs[rb_idx];

  always @(posedge clk) begin
    if (w_en) begin regs[w_idx] <= w_dat; writes <= writes + 1; end
    if (done) dones <= dones + 1;
    if (m_rvalid) begin
      m_rvalid <= 1'b0; m_cnt <= 0;
    end else if (m_req) begin
      if (m_cnt == 2) begin
        m_rvalid <= 1'b1; m_rdata <= m_addr * 3 + 32'h5000;
      end else m_cnt <= m_cnt + 1;
    end
  end

  ea_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .ri_i(ri), .rj_i(rj),
    .field_i(field), .pc_i(pc), .rd_a_idx_o(ra_idx), .rd_a_data_i(ra_dat),
    .rd_b_idx_o(rb_idx), .rd_b_data_i(rb_dat), .wr_en_o(w_en), .wr_idx_o(w_idx),
    .wr_data_o(w_dat), .mem_req_o(m_req), .mem_addr_o(m_addr), .mem_rvalid_i(m_rvalid),
    .mem_rdata_i(m_rdata), .busy_o(busy), .done_o(done), .ea_o(ea), .is_imm_o(is_imm),
    .is_reg_o(is_reg), .illegal_o(ill)
  );

  // {mode, ri, rj, field, pc, expected ea, kind: 0 addr 1 imm 2 reg 3 illegal}
  localparam int NV = 13;
  localparam logic [91:0] VEC [NV] = '{
    {4'd0,  3'd3, 3'd0, 16'h0000, 32'h0,     32'h0,         2'd2},  // R1
    {4'd1,  3'd0, 3'd0, 16'hFFF0, 32'h0,     32'hFFFF_FFF0, 2'd1},  // R2
    {4'd1,  3'd0, 3'd0, 16'h0123, 32'h0,     32'h0000_0123, 2'd1},  // R2
    {4'd2,  3'd0, 3'd0, 16'h8004, 32'h0,     32'h0000_8004, 2'd0},  // R3
    {4'd3,  3'd2, 3'd0, 16'h0000, 32'h0,     32'h0000_1200, 2'd0},  // R4
    {4'd5,  3'd1, 3'd0, 16'd20,   32'h0,     32'h0000_1114, 2'd0},  // R6
    {4'd5,  3'd4, 3'd0, 16'hFFFC, 32'h0,     32'h0000_13FC, 2'd0},  // R6
    {4'd6,  3'd1, 3'd2, 16'h7777, 32'h0,     32'h0000_2300, 2'd0},  // R7
    {4'd7,  3'd3, 3'd5, 16'd8,    32'h0,     32'h0000_2808, 2'd0},  // R7
    {4'd8,  3'd0, 3'd0, 16'hFFF0, 32'd1016,  32'd1000,      2'd0},  // R8
    {4'd8,  3'd0, 3'd0, 16'h0010, 32'h2000,  32'h0000_2010, 2'd0},  // R8
    {4'd11, 3'd1, 3'd0, 16'h0040, 32'h0,     32'h0,         2'd3},  // R11
    {4'd15, 3'd2, 3'd0, 16'h0040, 32'h0,     32'h0,         2'd3}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one request; returns cycles until done (0 = timeout)
  task automatic issue(input logic [3:0] md, input logic [2:0] a, input logic [2:0] b,
                       input logic [15:0] f, input logic [31:0] p, output int lat);
    @(negedge clk);
    mode = md; ri = a; rj = b; field = f; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 1; i < 20; i++) begin
      if (done) begin lat = i; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [1:0] kind_now();
    return ill ? 2'd3 : is_reg ? 2'd2 : is_imm ? 2'd1 : 2'd0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, w0, d0;
    for (int i = 0; i < 8; i++) regs[i] = 32'h1000 + i * 32'h100;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset", {28'd0, done, busy, m_req, w_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][91:88], VEC[v][87:85], VEC[v][84:82], VEC[v][81:66], VEC[v][65:34], lat);
      chk("R12 latency", lat, 1);
      chk($sformatf("R1-R11 ea vec%0d", v), ea, VEC[v][33:2]);
      chk($sformatf("R1-R11 kind vec%0d", v), {30'd0, kind_now()}, {30'd0, VEC[v][1:0]});
    end
    @(negedge clk);
    // R6 R1 R11: no writeback or memory access from non-stepping modes
    chk("R6 no write", writes, 0);
    chk("R6 r1 kept", regs[1], 32'h1100);
    chk("R6 r4 kept", regs[4], 32'h1400);
    chk("R11 no mem", {31'd0, m_req}, 32'd0);

    // R9 post-increment
    issue(4'd9, 3'd6, 3'd0, 16'h0, 32'h0, lat);
    chk("R9 ea", ea, 32'h1600);
    chk("R9 wr same cycle", {31'd0, w_en}, 32'd1);
    chk("R9 wr data", w_dat, 32'h1604);
    @(negedge clk);
    chk("R9 reg stepped", regs[6], 32'h1604);
    issue(4'd9, 3'd6, 3'd0, 16'h0, 32'h0, lat);
    chk("R9 second ea", ea, 32'h1604);
    @(negedge clk);
    chk("R9 second step", regs[6], 32'h1608);

    // R10 pre-decrement
    issue(4'd10, 3'd7, 3'd0, 16'h0, 32'h0, lat);
    chk("R10 ea", ea, 32'h16FC);
    chk("R10 wr idx", {29'd0, w_idx}, 32'd7);
    @(negedge clk);
    chk("R10 reg stepped", regs[7], 32'h16FC);

    // R5 memory pointer, with a start during busy (R12)
    @(negedge clk);
    d0 = dones; w0 = writes;
    mode = 4'd4; field = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 req", {31'd0, m_req}, 32'd1);
    chk("R5 addr", m_addr, 32'h0000_0040);
    chk("R12 busy", {31'd0, busy}, 32'd1);
    mode = 4'd1; field = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 addr held", m_addr, 32'h0000_0040);
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) begin lat = 1; break; end
      @(negedge clk);
    end
    chk("R5 done", lat, 1);
    chk("R5 ea", ea, 32'h50C0);
    chk("R5 flags", {30'd0, kind_now()}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R12 busy start ignored", dones - d0, 1);
    chk("R5 no write", writes - w0, 0);
    chk("R5 idle", {31'd0, m_req}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule